// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block turns one-shot register writes into complete flash command transactions. Software fills the block's control registers: flash address, addressing width, read speed, transfer sizes and the status value to write. It also fills a local program buffer. It then writes a 1 to bit 0 of the register that belongs to the wanted operation. The sequencer builds the byte stream for that operation and hands it one byte at a time to an external byte-wide SPI shifter. The stream is the opcode, then the address, then an optional dummy byte, then the data. Bytes returned by the shifter are stored in a local read buffer or in small result registers.

Each byte handed to the shifter carries a flag that marks it as the last byte of the transaction, so the shifter knows when to release chip select. The busy flag the block reports is the OR of its own activity and the shifter's busy line. Any operation trigger that arrives while that flag is high is dropped. Polling the flash's write-in-progress bit is left to software, which uses the status read operation for it.

The register space is split into three windows by the two top address bits: 00 control registers, 01 program buffer, 10 read buffer. In the buffer windows the low address bits give the byte index.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, busy_o, sh_start and wp_o are low, and the status result (control index 22) and ID result (control index 23) read as zero.
- R2: A write to control index 0..12 with data bit 0 set launches that operation. The indexes are: 0 page read, 1 page program, 2 erase 4 KB, 3 erase 32 KB, 4 erase 64 KB, 5 chip erase, 6 write enable, 7 write disable, 8 power-down, 9 release power-down, 10 status read, 11 status write, 12 ID read. A write with bit 0 clear produces no shifter activity.
- R3: Write enable, write disable, power-down, release and chip erase each send exactly one byte: 0x06, 0x04, 0xB9, 0xAB and 0xC7 respectively. Every transaction flags its final byte, and only that byte, with sh_last.
- R4: The 4 KB, 32 KB and 64 KB erases send 0x20, 0x52 and 0xD8 respectively. The opcode is followed by the flash address (control index 16), most significant byte first. Three bytes (address bits 23:0) are sent when configuration bit 0 (control index 17) is 0, and four bytes when it is 1.
- R5: Page program sends 0x02 and the address. It then sends program buffer bytes 0 upward, as many as the program size (control index 19). A size of 0 sends only the opcode and address.
- R6: Page read sends 0x03 and the address. It then clocks in as many bytes as the read size (control index 20) and stores them in read buffer bytes 0 upward. With configuration bit 1 set it sends 0x0B and one dummy byte 0x00 after the address. The byte received during the dummy slot is discarded.
- R7: Status read (0x05) and ID read (0x9F) each clock in one byte after the opcode. That byte goes to the status result or the ID result. Status write sends 0x01 followed by the value at control index 21.
- R8: A size written above PAGE_BYTES is stored and read back as PAGE_BYTES.
- R9: busy_o is high from the cycle after a launch until the final byte completes, and whenever sh_busy is high. Triggers written while busy_o is high are ignored.
- R10: wp_o follows bit 0 of control index 18 from the cycle after that register is written.
- R11: A new sh_start is never issued before sh_done has answered the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW | Register write address (window in top two bits) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | AW | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| sh_start | output | 1 | Pulse: shifter sends sh_tx_byte |
| sh_tx_byte | output | 8 | Byte to shift out |
| sh_last | output | 1 | Byte is the last of the transaction |
| sh_done | input | 1 | Pulse: shifter finished the byte |
| sh_rx_byte | input | 8 | Byte shifted in, valid with sh_done |
| sh_busy | input | 1 | Shifter busy |
| busy_o | output | 1 | Shared busy flag |
| wp_o | output | 1 | Flash write-protect output |

## Verification
The bench builds the block with PAGE_BYTES set to 16. This makes full-page reads and programs short, so many random transactions fit in the run. It also makes the size saturation boundary reachable with small written values. With that page size the register windows sit at 0, 32 and 64. The bench models the shifter with a fixed three-cycle byte latency. It tags each received byte with its position in the transaction, so a misplaced dummy or data byte shows up in the read buffer.

// File: rtl/flash_seq_pkg.sv
// Shared types and constants for the SPI flash command sequencer.
// Assumes at most 16 operations (4-bit operation code).
package flash_seq_pkg;

    localparam int NUM_OPS = 13;

    typedef enum logic [3:0] {
        OP_PREAD  = 4'd0,
        OP_PPROG  = 4'd1,
        OP_ER4K   = 4'd2,
        OP_ER32K  = 4'd3,
        OP_ER64K  = 4'd4,
        OP_CHIPER = 4'd5,
        OP_WREN   = 4'd6,
        OP_WRDI   = 4'd7,
        OP_PDOWN  = 4'd8,
        OP_PUP    = 4'd9,
        OP_RDSR   = 4'd10,
        OP_WRSR   = 4'd11,
        OP_RDID   = 4'd12
    } op_e;

    localparam logic [4:0] RG_FADDR = 5'd16;
    localparam logic [4:0] RG_CFG   = 5'd17;
    localparam logic [4:0] RG_WP    = 5'd18;
    localparam logic [4:0] RG_PSIZE = 5'd19;
    localparam logic [4:0] RG_RSIZE = 5'd20;
    localparam logic [4:0] RG_WRSR  = 5'd21;
    localparam logic [4:0] RG_STAT  = 5'd22;
    localparam logic [4:0] RG_ID    = 5'd23;
    localparam logic [4:0] RG_BUSY  = 5'd24;

    localparam logic [1:0] WIN_CTL  = 2'd0;
    localparam logic [1:0] WIN_PBUF = 2'd1;
    localparam logic [1:0] WIN_RBUF = 2'd2;

    // Opcode byte for an operation; fast selects the fast page read.
    function automatic logic [7:0] op_code(op_e op, logic fast);
        case (op)
            OP_PREAD:  op_code = fast ? 8'h0B : 8'h03;
            OP_PPROG:  op_code = 8'h02;
            OP_ER4K:   op_code = 8'h20;
            OP_ER32K:  op_code = 8'h52;
            OP_ER64K:  op_code = 8'hD8;
            OP_CHIPER: op_code = 8'hC7;
            OP_WREN:   op_code = 8'h06;
            OP_WRDI:   op_code = 8'h04;
            OP_PDOWN:  op_code = 8'hB9;
            OP_PUP:    op_code = 8'hAB;
            OP_RDSR:   op_code = 8'h05;
            OP_WRSR:   op_code = 8'h01;
            OP_RDID:   op_code = 8'h9F;
            default:   op_code = 8'h00;
        endcase
    endfunction

    // True for operations that carry the flash address after the opcode.
    function automatic logic op_has_addr(op_e op);
        op_has_addr = (op == OP_PREAD) || (op == OP_PPROG) || (op == OP_ER4K) ||
                      (op == OP_ER32K) || (op == OP_ER64K);
    endfunction

endpackage

// File: rtl/flash_seq_pick.sv
// Turns the per-operation trigger vector into one launch request.
// The lowest-numbered set bit is selected. Purely combinational.
module flash_seq_pick
    import flash_seq_pkg::*;
(
    input  logic [NUM_OPS-1:0] req,
    output logic               any,
    output op_e                sel
);

    // Scan from the top so the lowest set index is left in sel.
    always_comb begin
        any = |req;
        sel = OP_PREAD;
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (req[i]) sel = op_e'(4'(i));
        end
    end

    // R2
    always_comb begin
        if (any) pick_hit_chk: assert (req[sel]);
    end

endmodule

// File: rtl/flash_seq_regs.sv
// Control registers, program/read byte buffers and result registers.
// Assumes AW-2 >= 5 and AW-2 >= IW; the window is taken from the top two address bits.
module flash_seq_regs
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int AW         = 10,
    parameter int IW         = 8,
    parameter int SW         = 9
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [31:0]        rd_data,
    input  logic               busy,
    output logic [NUM_OPS-1:0] trig,
    output logic [31:0]        faddr,
    output logic               addr32,
    output logic               fast,
    output logic               wp,
    output logic [SW-1:0]      psize,
    output logic [SW-1:0]      rsize,
    output logic [7:0]         wrsr_val,
    input  logic [IW-1:0]      pb_idx,
    output logic [7:0]         pb_byte,
    input  logic               rb_we,
    input  logic [IW-1:0]      rb_idx,
    input  logic [7:0]         rb_data,
    input  logic               stat_we,
    input  logic               id_we,
    input  logic [7:0]         rx_data
);

    localparam logic [SW-1:0] SIZE_MAX = SW'(PAGE_BYTES);

    logic [1:0]    wwin, rwin;
    logic [4:0]    wctl, rctl;
    logic [IW-1:0] wbi, rbi;
    logic [SW-1:0] size_in;
    logic [7:0]    stat_q, id_q;
    logic [7:0]    pbuf [PAGE_BYTES];
    logic [7:0]    rbuf [PAGE_BYTES];

    assign wwin = wr_addr[AW-1:AW-2];
    assign rwin = rd_addr[AW-1:AW-2];
    assign wctl = wr_addr[4:0];
    assign rctl = rd_addr[4:0];
    assign wbi  = wr_addr[IW-1:0];
    assign rbi  = rd_addr[IW-1:0];

    // Saturate a written size at the page size.
    assign size_in = (wr_data > 32'(PAGE_BYTES)) ? SIZE_MAX : wr_data[SW-1:0];

    // Decode a trigger write into the one-hot request vector.
    always_comb begin
        trig = '0;
        if (wr_en && wwin == WIN_CTL && wr_data[0] && wctl < 5'(NUM_OPS))
            trig[wctl[3:0]] = 1'b1;
    end

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr    <= '0;
            addr32   <= 1'b0;
            fast     <= 1'b0;
            wp       <= 1'b0;
            psize    <= '0;
            rsize    <= '0;
            wrsr_val <= '0;
        end else if (wr_en && wwin == WIN_CTL) begin
            case (wctl)
                RG_FADDR: faddr    <= wr_data;
                RG_CFG:   begin addr32 <= wr_data[0]; fast <= wr_data[1]; end
                RG_WP:    wp       <= wr_data[0];
                RG_PSIZE: psize    <= size_in;
                RG_RSIZE: rsize    <= size_in;
                RG_WRSR:  wrsr_val <= wr_data[7:0];
                default:  ;
            endcase
        end
    end

    // Result registers loaded by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            id_q   <= '0;
        end else begin
            if (stat_we) stat_q <= rx_data;
            if (id_we)   id_q   <= rx_data;
        end
    end

    // Program buffer: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
        end else if (wr_en && wwin == WIN_PBUF) begin
            pbuf[wbi] <= wr_data[7:0];
        end
    end

    // Read buffer: written by the sequencer only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) rbuf[i] <= '0;
        end else if (rb_we) begin
            rbuf[rb_idx] <= rb_data;
        end
    end

    assign pb_byte = pbuf[pb_idx];

    // Read-back multiplexer.
    always_comb begin
        rd_data = '0;
        case (rwin)
            WIN_CTL: begin
                case (rctl)
                    RG_FADDR: rd_data = faddr;
                    RG_CFG:   rd_data = {30'd0, fast, addr32};
                    RG_WP:    rd_data = {31'd0, wp};
                    RG_PSIZE: rd_data = 32'(psize);
                    RG_RSIZE: rd_data = 32'(rsize);
                    RG_WRSR:  rd_data = {24'd0, wrsr_val};
                    RG_STAT:  rd_data = {24'd0, stat_q};
                    RG_ID:    rd_data = {24'd0, id_q};
                    RG_BUSY:  rd_data = {31'd0, busy};
                    default:  rd_data = '0;
                endcase
            end
            WIN_PBUF: rd_data = {24'd0, pbuf[rbi]};
            WIN_RBUF: rd_data = {24'd0, rbuf[rbi]};
            default:  rd_data = '0;
        endcase
    end

    // R8
    size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psize <= SIZE_MAX) && (rsize <= SIZE_MAX));

    // R10
    wp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wwin == WIN_CTL && wctl == RG_WP) |=> (wp == $past(wr_data[0])));

endmodule

// File: rtl/flash_seq_ctrl.sv
// Byte sequencer: builds opcode, address, dummy and data bytes for one
// operation and exchanges them with the shifter one byte at a time.
// Assumes launch only arrives while idle, and each sh_start is answered by one sh_done.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int IW = 8,
    parameter int SW = 9,
    parameter int CW = 9
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  op_e           launch_op,
    input  logic [31:0]   faddr,
    input  logic          addr32,
    input  logic          fast,
    input  logic [SW-1:0] psize,
    input  logic [SW-1:0] rsize,
    input  logic [7:0]    wrsr_val,
    output logic [IW-1:0] pb_idx,
    input  logic [7:0]    pb_byte,
    output logic          sh_start,
    output logic [7:0]    sh_tx_byte,
    output logic          sh_last,
    input  logic          sh_done,
    output logic          rb_we,
    output logic [IW-1:0] rb_idx,
    output logic          stat_we,
    output logic          id_we,
    output logic          active
);

    typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_e;

    st_e           st;
    op_e           op_q;
    logic [31:0]   addr_q;
    logic          a32_q, fast_q;
    logic [CW-1:0] idx, last;
    logic [2:0]    hdr, hdr_n, na, ab, sel;
    logic [SW-1:0] dn;
    logic [CW-1:0] dpos;
    logic          in_data, cap;

    // Header length and data count of the operation being launched.
    always_comb begin
        hdr_n = 3'd1;
        if (op_has_addr(launch_op)) hdr_n = hdr_n + (addr32 ? 3'd4 : 3'd3);
        if (launch_op == OP_PREAD && fast) hdr_n = hdr_n + 3'd1;
        case (launch_op)
            OP_PREAD:                  dn = rsize;
            OP_PPROG:                  dn = psize;
            OP_RDSR, OP_WRSR, OP_RDID: dn = SW'(1);
            default:                   dn = '0;
        endcase
    end

    // Sequencer state, latched operation and byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            op_q   <= OP_PREAD;
            addr_q <= '0;
            a32_q  <= 1'b0;
            fast_q <= 1'b0;
            idx    <= '0;
            hdr    <= 3'd1;
            last   <= '0;
        end else begin
            case (st)
                S_IDLE: if (launch) begin
                    op_q   <= launch_op;
                    addr_q <= faddr;
                    a32_q  <= addr32;
                    fast_q <= fast;
                    idx    <= '0;
                    hdr    <= hdr_n;
                    last   <= CW'(hdr_n) + CW'(dn) - CW'(1);
                    st     <= S_SEND;
                end
                S_SEND: st <= S_WAIT;
                S_WAIT: if (sh_done) begin
                    if (idx == last) st <= S_IDLE;
                    else begin
                        idx <= idx + CW'(1);
                        st  <= S_SEND;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign na      = a32_q ? 3'd4 : 3'd3;
    assign ab      = idx[2:0] - 3'd1;
    assign sel     = na - 3'd1 - ab;
    assign in_data = (idx >= CW'(hdr));
    assign dpos    = idx - CW'(hdr);
    assign pb_idx  = dpos[IW-1:0];
    assign rb_idx  = dpos[IW-1:0];

    // Byte for the current position: opcode, address, dummy or data.
    always_comb begin
        if (idx == '0) begin
            sh_tx_byte = op_code(op_q, fast_q);
        end else if (!in_data) begin
            if (op_has_addr(op_q) && idx <= CW'(na))
                sh_tx_byte = addr_q[{sel[1:0], 3'b000} +: 8];
            else
                sh_tx_byte = 8'h00;
        end else begin
            case (op_q)
                OP_PPROG: sh_tx_byte = pb_byte;
                OP_WRSR:  sh_tx_byte = wrsr_val;
                default:  sh_tx_byte = 8'h00;
            endcase
        end
    end

    assign sh_start = (st == S_SEND);
    assign sh_last  = sh_start && (idx == last);
    assign active   = (st != S_IDLE);
    assign cap      = (st == S_WAIT) && sh_done && in_data;
    assign rb_we    = cap && (op_q == OP_PREAD);
    assign stat_we  = cap && (op_q == OP_RDSR);
    assign id_we    = cap && (op_q == OP_RDID);

    // R11
    one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);

    // R9
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> active);

    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(op_q));

    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sh_start);

    // R3
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && sh_done && idx == last) |=> !active);

endmodule

// File: rtl/spi_flash_cmd_seq.sv
// Top level: register file, trigger picker and byte sequencer.
// Assumes PAGE_BYTES is a power of two of at least 2, and a byte-wide SPI shifter outside.
module spi_flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    localparam int IW = $clog2(PAGE_BYTES),
    localparam int OW = (IW > 5) ? IW : 5,
    localparam int AW = OW + 2,
    localparam int SW = $clog2(PAGE_BYTES + 1),
    localparam int CW = $clog2(PAGE_BYTES + 7)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_addr,
    input  logic [31:0]   reg_wr_data,
    input  logic [AW-1:0] reg_rd_addr,
    output logic [31:0]   reg_rd_data,
    output logic          sh_start,
    output logic [7:0]    sh_tx_byte,
    output logic          sh_last,
    input  logic          sh_done,
    input  logic [7:0]    sh_rx_byte,
    input  logic          sh_busy,
    output logic          busy_o,
    output logic          wp_o
);

    logic [NUM_OPS-1:0] trig;
    logic               any, launch, active;
    op_e                pick_op;
    logic [31:0]        faddr;
    logic               addr32, fast;
    logic [SW-1:0]      psize, rsize;
    logic [7:0]         wrsr_val, pb_byte;
    logic [IW-1:0]      pb_idx, rb_idx;
    logic               rb_we, stat_we, id_we;

    assign busy_o = active | sh_busy;
    assign launch = any && !busy_o;

    flash_seq_regs #(.PAGE_BYTES(PAGE_BYTES), .AW(AW), .IW(IW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data), .busy(busy_o),
        .trig(trig), .faddr(faddr), .addr32(addr32), .fast(fast), .wp(wp_o),
        .psize(psize), .rsize(rsize), .wrsr_val(wrsr_val),
        .pb_idx(pb_idx), .pb_byte(pb_byte),
        .rb_we(rb_we), .rb_idx(rb_idx), .rb_data(sh_rx_byte),
        .stat_we(stat_we), .id_we(id_we), .rx_data(sh_rx_byte)
    );

    flash_seq_pick u_pick (.req(trig), .any(any), .sel(pick_op));

    flash_seq_ctrl #(.IW(IW), .SW(SW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_op(pick_op),
        .faddr(faddr), .addr32(addr32), .fast(fast),
        .psize(psize), .rsize(rsize), .wrsr_val(wrsr_val),
        .pb_idx(pb_idx), .pb_byte(pb_byte),
        .sh_start(sh_start), .sh_tx_byte(sh_tx_byte), .sh_last(sh_last),
        .sh_done(sh_done),
        .rb_we(rb_we), .rb_idx(rb_idx),
        .stat_we(stat_we), .id_we(id_we), .active(active)
    );

    // R9
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && !active) |=> !active);

endmodule

// File: tb/spi_flash_cmd_seq_test.sv
module spi_flash_cmd_seq_test;

    localparam int PB = 16;
    localparam int AW = 7;
    localparam int PBUF_BASE = 32;
    localparam int RBUF_BASE = 64;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_wr_addr = '0;
    logic [31:0]   reg_wr_data = '0;
    logic [AW-1:0] reg_rd_addr = '0;
    logic [31:0]   reg_rd_data;
    logic          sh_start, sh_last, busy_o, wp_o;
    logic [7:0]    sh_tx_byte;
    logic          sh_done;
    logic [7:0]    sh_rx_byte;
    logic          m_busy, ext_busy = 1'b0;

    always #2 clk = ~clk;

    spi_flash_cmd_seq #(.PAGE_BYTES(PB)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .sh_start(sh_start), .sh_tx_byte(sh_tx_byte), .sh_last(sh_last),
        .sh_done(sh_done), .sh_rx_byte(sh_rx_byte), .sh_busy(m_busy | ext_busy),
        .busy_o(busy_o), .wp_o(wp_o)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] tag = 8'h00;

    // Shifter model: logs each byte, answers after LAT cycles.
    logic [7:0] log_b [0:4095];
    logic       log_l [0:4095];
    int         n_log = 0, tpos = 0, cur_pos = 0, cnt = 0, overlap = 0;

    function automatic logic [7:0] rxval(int pos, logic [7:0] t);
        return 8'(pos * 37) ^ t;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            sh_done <= 1'b0; sh_rx_byte <= '0; m_busy <= 1'b0; cnt <= 0; tpos <= 0;
        end else begin
            sh_done <= 1'b0;
            if (sh_start) begin
                if (cnt != 0) overlap <= overlap + 1;
                log_b[n_log] <= sh_tx_byte;
                log_l[n_log] <= sh_last;
                n_log   <= n_log + 1;
                cur_pos <= tpos;
                tpos    <= sh_last ? 0 : tpos + 1;
                m_busy  <= 1'b1;
                cnt     <= LAT;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    sh_done <= 1'b1;
                    sh_rx_byte <= rxval(cur_pos, tag);
                    m_busy <= 1'b0;
                end
            end
        end
    end

    // Bench model of the software-visible state.
    logic [31:0] m_addr = 0;
    bit          m_a32 = 0, m_fast = 0;
    int          m_psize = 0, m_rsize = 0;
    logic [7:0]  m_wrsr = 0;
    logic [7:0]  m_pbuf [PB];
    logic [7:0]  m_rbuf [PB];
    logic [7:0]  exp_b [0:63];
    int          exp_n, exp_hdr;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = AW'(a); reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_rd_addr = AW'(a);
        #1;
        d = reg_rd_data;
    endtask

    function automatic string req_of(int op);
        case (op)
            0: return "R6";
            1: return "R5";
            2, 3, 4: return "R4";
            10, 11, 12: return "R7";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [7:0] opc(int op);
        logic [7:0] t [13] = '{8'h03, 8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h06,
                               8'h04, 8'hB9, 8'hAB, 8'h05, 8'h01, 8'h9F};
        if (op == 0 && m_fast) return 8'h0B;
        return t[op];
    endfunction

    // Build the expected byte stream from the bench model.
    task automatic mk_exp(int op);
        int na;
        exp_n = 0;
        exp_b[exp_n++] = opc(op);
        if (op <= 4) begin
            na = m_a32 ? 4 : 3;
            for (int k = 0; k < na; k++) exp_b[exp_n++] = 8'(m_addr >> (8 * (na - 1 - k)));
        end
        if (op == 0 && m_fast) exp_b[exp_n++] = 8'h00;
        exp_hdr = exp_n;
        case (op)
            0: for (int i = 0; i < m_rsize; i++) exp_b[exp_n++] = 8'h00;
            1: for (int i = 0; i < m_psize; i++) exp_b[exp_n++] = m_pbuf[i];
            10, 12: exp_b[exp_n++] = 8'h00;
            11: exp_b[exp_n++] = m_wrsr;
            default: ;
        endcase
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic run_op(int op);
        int base, bad;
        logic [31:0] v;
        string r;
        r = req_of(op);
        tag = 8'($urandom);
        mk_exp(op);
        base = n_log;
        wr(op, 32'h1);
        wait_idle();
        check(n_log - base == exp_n, r, $sformatf("op %0d byte count", op), n_log - base, exp_n);
        bad = 0;
        for (int i = 0; i < exp_n && i < n_log - base; i++) begin
            if (log_b[base + i] !== exp_b[i]) bad++;
            if (log_l[base + i] !== (i == exp_n - 1)) bad++;
        end
        check(bad == 0, r, $sformatf("op %0d byte stream / last flag (R3)", op), bad, 0);
        if (op == 0) begin
            for (int i = 0; i < m_rsize; i++) m_rbuf[i] = rxval(exp_hdr + i, tag);
            bad = 0;
            for (int i = 0; i < PB; i++) begin
                rd(RBUF_BASE + i, v);
                if (v !== {24'd0, m_rbuf[i]}) bad++;
            end
            check(bad == 0, "R6", "read buffer contents", bad, 0);
        end
        if (op == 10) begin
            rd(22, v);
            check(v == {24'd0, rxval(1, tag)}, "R7", "status result", v, {24'd0, rxval(1, tag)});
        end
        if (op == 12) begin
            rd(23, v);
            check(v == {24'd0, rxval(1, tag)}, "R7", "ID result", v, {24'd0, rxval(1, tag)});
        end
    endtask

    task automatic set_cfg(logic [31:0] a, bit a32, bit f);
        m_addr = a; m_a32 = a32; m_fast = f;
        wr(16, a);
        wr(17, {30'd0, f, a32});
    endtask

    task automatic set_sizes(int p, int r);
        m_psize = (p > PB) ? PB : p;
        m_rsize = (r > PB) ? PB : r;
        wr(19, p);
        wr(20, r);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < PB; i++) begin m_pbuf[i] = 0; m_rbuf[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !sh_start && !wp_o, "R1", "outputs after reset",
              {busy_o, sh_start, wp_o}, 0);
        rd(22, v); check(v == 0, "R1", "status result after reset", v, 0);
        rd(23, v); check(v == 0, "R1", "ID result after reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: write protect output
        wr(18, 1); check(wp_o == 1'b1, "R10", "wp set", wp_o, 1);
        wr(18, 0); check(wp_o == 1'b0, "R10", "wp clear", wp_o, 0);

        // R2: trigger with bit 0 clear does nothing
        base = n_log;
        wr(6, 32'hFFFF_FFFE);
        repeat (10) @(negedge clk);
        check(n_log == base && !busy_o, "R2", "bit0 clear ignored", n_log - base, 0);

        // R8: size saturation
        set_sizes(100, PB + 1);
        rd(19, v); check(v == PB, "R8", "program size saturates", v, PB);
        rd(20, v); check(v == PB, "R8", "read size saturates", v, PB);

        // Fill program buffer
        for (int i = 0; i < PB; i++) begin
            m_pbuf[i] = 8'($urandom);
            wr(PBUF_BASE + i, {24'd0, m_pbuf[i]});
        end

        // Directed: single-byte ops R3
        for (int op = 5; op <= 9; op++) run_op(op);
        // R4: erases in 24- and 32-bit modes
        set_cfg(32'hA1B2_C3D4, 0, 0); run_op(2);
        set_cfg(32'hA1B2_C3D4, 1, 0); run_op(3); run_op(4);
        // R5: full page and zero-size program
        run_op(1);
        set_sizes(0, 0); run_op(1);
        // R6: zero-size read, normal and fast full-page read
        run_op(0);
        set_sizes(PB, PB); set_cfg(32'h0012_3456, 0, 0); run_op(0);
        set_cfg(32'h89AB_CDEF, 1, 1); run_op(0);
        // R7
        m_wrsr = 8'h5C; wr(21, 32'h5C); run_op(11); run_op(10); run_op(12);

        // R9: trigger while active is ignored
        base = n_log;
        wr(5, 1);
        wr(12, 1);
        wait_idle();
        repeat (8) @(negedge clk);
        check(n_log - base == 1 && log_b[base] == 8'hC7, "R9", "trigger while active ignored",
              n_log - base, 1);
        // R9: trigger while shifter busy is ignored
        ext_busy = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b1, "R9", "busy follows shifter busy", busy_o, 1);
        base = n_log;
        wr(6, 1);
        ext_busy = 1'b0;
        repeat (10) @(negedge clk);
        check(n_log == base && !busy_o, "R9", "trigger during shifter busy ignored", n_log - base, 0);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            set_cfg($urandom, 1'($urandom), 1'($urandom));
            set_sizes($urandom % (PB + 4), $urandom % (PB + 4));
            if ($urandom % 2) begin
                m_wrsr = 8'($urandom); wr(21, {24'd0, m_wrsr});
            end
            run_op($urandom % 13);
        end

        // R11: no overlapping byte requests seen by the model
        check(overlap == 0, "R11", "byte issued before previous done", overlap, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule